// File: doc/BRIEF.md
# ChaCha Keystream Block Engine

This block computes ChaCha keystream from a 128-bit constant, a 256-bit key, a 96-bit nonce and a 32-bit block counter. It runs a programmable even number of rounds, alternating column and diagonal rounds. After the last round it adds the starting state back in to form a 64-byte block. One full round of four quarter-rounds completes per clock.

A request is made with a single-cycle `start`. In single mode one block is produced. In burst mode the engine generates four blocks back to back, with counters `ctr_in` to `ctr_in+3`, into a 256-byte output. When XOR mode is selected, the keystream is combined byte by byte with a 256-byte input buffer, so the same request encrypts or decrypts. The caller holds nothing after the start cycle because all request fields are captured then. `busy` covers the whole job, and a one-cycle `done` marks the point where `dout` is valid.

Top module: `chacha_burst_core`

## Requirements
- R1: The starting state is built from the request in this order: words 0-3 from `const_in[32*i+:32]`, words 4-11 from `key_in[32*(i-4)+:32]`, word 12 from the block counter, and words 13-15 from `nonce_in[32*(i-13)+:32]`. Every byte vector is little-endian, so byte k sits at bits `[8*k+:8]`.
- R2: Each quarter-round applies add/xor/rotate-left with rotations 16, 12, 8 and 7, using mod 2^32 sums. Rounds alternate column groups {0,4,8,12}.. and diagonal groups {0,5,10,15},{1,6,11,12},{2,7,8,13},{3,4,9,14}, starting with a column round. With 20 rounds and all-zero key, nonce and counter, the first keystream bytes are 76 b8 e0 ad a0 f1 3d 90 ....
- R3: For an accepted request with round count N, `done` is high for exactly one cycle, B*(N+2) clocks after the start edge, where B is 1 in single mode and 4 in burst mode. `busy` is high from the cycle after the start edge until `done`.
- R4: In burst mode (`burst_en`=1), block b (b = 0..3) uses counter `ctr_in+b` and occupies output bytes 64*b to 64*b+63. Within a block, output word w is bytes 4w..4w+3, low byte first.
- R5: The per-block counter wraps modulo 2^32 inside a burst. The nonce words never receive a carry.
- R6: With `xor_en`=1, every produced output byte is the keystream byte XOR the `din` byte at the same offset.
- R7: A start with a round count of zero or an odd value is refused. `err` pulses for one cycle after that edge, `busy` and `done` stay low, and `dout` keeps its previous value.
- R8: A `start` seen while `busy` is high has no effect on the running job or its result, and it produces no extra `done`. While idle without a start, `dout` holds its value.
- R9: In single mode, output bytes 64..255 are zero, in XOR mode as well. An accepted start clears the previous result.
- R10: After a synchronous reset, `busy`, `done` and `err` are 0 and `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| burst_en | input | 1 | 1: four consecutive blocks, 0: one block |
| xor_en | input | 1 | 1: XOR keystream with `din` |
| rounds | input | ROUND_W (6) | Round count, must be even and nonzero |
| const_in | input | 128 | Constant, little-endian bytes |
| key_in | input | 256 | Key, little-endian bytes |
| nonce_in | input | 96 | Nonce, little-endian bytes |
| ctr_in | input | 32 | Starting block counter |
| din | input | BLOCKS*512 (2048) | Data combined in XOR mode |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| dout | output | BLOCKS*512 (2048) | Keystream or XOR result |

## Verification
The bench builds the engine with its defaults, BLOCKS=4 and ROUND_W=6. That makes round counts up to 62 legal, so 8, 12 and 20 rounds can be run next to refused counts of 0 and 7. The four-block width lets a burst start at counter 0xFFFFFFFE and cross the 32-bit wrap. An independent software model of the block function produces the expected data for each job and the exact cycle in which `done` is due. The zero-key 20-round vector anchors that model to known bytes.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 16;
  localparam int BLK_BITS  = WORD_W * NUM_WORDS;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NUM_WORDS-1:0] state_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_FIN
  } fsm_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
  import chacha_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1, a2, b2, c2, d2;

  always_comb begin
    a1 = a_i + b_i;
    d1 = rotl(d_i ^ a1, 16);
    c1 = c_i + d1;
    b1 = rotl(b_i ^ c1, 12);
    a2 = a1 + b1;
    d2 = rotl(d1 ^ a2, 8);
    c2 = c1 + d2;
    b2 = rotl(b1 ^ c2, 7);
  end

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;
endmodule

// File: rtl/chacha_round.sv
module chacha_round
  import chacha_pkg::*;
(
  input  state_t s_in,
  input  logic   diag,
  output state_t s_out
);
  localparam int LANES = 4;

  logic [3:0] ib [LANES];
  logic [3:0] ic [LANES];
  logic [3:0] id [LANES];
  word_t ra [LANES];
  word_t rb [LANES];
  word_t rc [LANES];
  word_t rd [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int CB = 4 + g;
    localparam int CC = 8 + g;
    localparam int CD = 12 + g;
    localparam int DB = 4 + ((g + 1) % LANES);
    localparam int DC = 8 + ((g + 2) % LANES);
    localparam int DD = 12 + ((g + 3) % LANES);

    assign ib[g] = diag ? 4'(DB) : 4'(CB);
    assign ic[g] = diag ? 4'(DC) : 4'(CC);
    assign id[g] = diag ? 4'(DD) : 4'(CD);

    chacha_qr u_qr (
      .a_i (s_in[g]),
      .b_i (s_in[ib[g]]),
      .c_i (s_in[ic[g]]),
      .d_i (s_in[id[g]]),
      .a_o (ra[g]),
      .b_o (rb[g]),
      .c_o (rc[g]),
      .d_o (rd[g])
    );
  end

  always_comb begin
    s_out = s_in;
    for (int g = 0; g < LANES; g++) begin
      s_out[g]     = ra[g];
      s_out[ib[g]] = rb[g];
      s_out[ic[g]] = rc[g];
      s_out[id[g]] = rd[g];
    end
  end
endmodule

// File: rtl/chacha_finalize.sv
module chacha_finalize
  import chacha_pkg::*;
(
  input  state_t              work,
  input  state_t              init,
  input  logic [BLK_BITS-1:0] din_blk,
  input  logic                xor_en,
  output logic [BLK_BITS-1:0] blk_out
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    word_t sum;
    assign sum = work[w] + init[w];
    assign blk_out[WORD_W*w +: WORD_W] =
      sum ^ (xor_en ? din_blk[WORD_W*w +: WORD_W] : '0);
  end
endmodule

// File: rtl/chacha_burst_core.sv
module chacha_burst_core
  import chacha_pkg::*;
#(
  parameter int BLOCKS  = 4,
  parameter int ROUND_W = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       burst_en,
  input  logic                       xor_en,
  input  logic [ROUND_W-1:0]         rounds,
  input  logic [127:0]               const_in,
  input  logic [255:0]               key_in,
  input  logic [95:0]                nonce_in,
  input  logic [31:0]                ctr_in,
  input  logic [BLOCKS*BLK_BITS-1:0] din,
  output logic                       busy,
  output logic                       done,
  output logic                       err,
  output logic [BLOCKS*BLK_BITS-1:0] dout
);
  localparam int BUF_BITS = BLOCKS * BLK_BITS;
  localparam int IDX_W    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
  localparam logic [IDX_W-1:0] LAST_BLK = IDX_W'(BLOCKS - 1);

  fsm_t                st_q;
  logic [IDX_W-1:0]    blk_q;
  logic [ROUND_W-1:0]  cnt_q;
  logic [ROUND_W-1:0]  rounds_l;
  logic                diag_q;
  logic                burst_l, xor_l;
  logic [127:0]        const_l;
  logic [255:0]        key_l;
  logic [95:0]         nonce_l;
  logic [31:0]         ctr_l;
  logic [BUF_BITS-1:0] din_q;
  logic [BUF_BITS-1:0] dout_q;
  logic                busy_q, done_q, err_q;
  state_t              work_q, work_nx, init_s;
  logic [BLK_BITS-1:0] fin_blk;
  logic                bad_cnt;

  assign bad_cnt = (rounds == '0) || rounds[0];

  // Starting state for the block currently being produced
  always_comb begin
    for (int i = 0; i < 4; i++) init_s[i] = const_l[32*i +: 32];
    for (int i = 0; i < 8; i++) init_s[4+i] = key_l[32*i +: 32];
    init_s[12] = ctr_l + 32'(blk_q);
    for (int i = 0; i < 3; i++) init_s[13+i] = nonce_l[32*i +: 32];
  end

  chacha_round u_round (
    .s_in  (work_q),
    .diag  (diag_q),
    .s_out (work_nx)
  );

  chacha_finalize u_fin (
    .work    (work_q),
    .init    (init_s),
    .din_blk (din_q[int'(blk_q)*BLK_BITS +: BLK_BITS]),
    .xor_en  (xor_l),
    .blk_out (fin_blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      blk_q    <= '0;
      cnt_q    <= '0;
      rounds_l <= '0;
      diag_q   <= 1'b0;
      burst_l  <= 1'b0;
      xor_l    <= 1'b0;
      const_l  <= '0;
      key_l    <= '0;
      nonce_l  <= '0;
      ctr_l    <= '0;
      din_q    <= '0;
      dout_q   <= '0;
      work_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (bad_cnt) begin
              err_q <= 1'b1;
            end else begin
              rounds_l <= rounds;
              burst_l  <= burst_en;
              xor_l    <= xor_en;
              const_l  <= const_in;
              key_l    <= key_in;
              nonce_l  <= nonce_in;
              ctr_l    <= ctr_in;
              din_q    <= din;
              dout_q   <= '0;
              blk_q    <= '0;
              busy_q   <= 1'b1;
              st_q     <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          work_q <= init_s;
          cnt_q  <= rounds_l;
          diag_q <= 1'b0;
          st_q   <= ST_RUN;
        end
        ST_RUN: begin
          work_q <= work_nx;
          cnt_q  <= cnt_q - 1'b1;
          diag_q <= ~diag_q;
          if (cnt_q == ROUND_W'(1)) st_q <= ST_FIN;
        end
        ST_FIN: begin
          dout_q[int'(blk_q)*BLK_BITS +: BLK_BITS] <= fin_blk;
          if (burst_l && (blk_q != LAST_BLK)) begin
            blk_q <= blk_q + 1'b1;
            st_q  <= ST_LOAD;
          end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;
  assign dout = dout_q;

  // R7: a refused count answers with err only
  assert_reject_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && start && bad_cnt) |=> (err && !busy));
  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !done));
  // R3: done is a single pulse and busy only drops with done
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R8: idle result holds without a start
  assert_hold_out_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(dout));
  // R2: the round counter never runs at zero
  assert_run_cnt_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |-> (cnt_q != '0));
endmodule

// File: tb/chacha_burst_core_tb.sv
module chacha_burst_core_tb;
  localparam int BLOCKS  = 4;
  localparam int ROUND_W = 6;
  localparam int BUF     = BLOCKS * 512;

  logic clk = 1'b0;
  logic rst;
  logic start, burst_en, xor_en;
  logic [ROUND_W-1:0] rounds;
  logic [127:0] const_in;
  logic [255:0] key_in;
  logic [95:0]  nonce_in;
  logic [31:0]  ctr_in;
  logic [BUF-1:0] din;
  logic busy, done, err;
  logic [BUF-1:0] dout;

  always #10 clk = ~clk;  // 50 MHz

  chacha_burst_core #(.BLOCKS(BLOCKS), .ROUND_W(ROUND_W)) u_dut (
    .clk, .rst, .start, .burst_en, .xor_en, .rounds, .const_in,
    .key_in, .nonce_in, .ctr_in, .din, .busy, .done, .err, .dout
  );

  typedef struct {
    logic [BUF-1:0] exp;
    int             due;
    string          tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  localparam logic [127:0] SIGMA =
    {32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [BUF-1:0] act, input logic [BUF-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent model of the block function
  function automatic bit [31:0] rl(bit [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic void qround(inout bit [31:0] a, inout bit [31:0] b,
                                 inout bit [31:0] c, inout bit [31:0] d);
    a += b; d = rl(d ^ a, 16);
    c += d; b = rl(b ^ c, 12);
    a += b; d = rl(d ^ a, 8);
    c += d; b = rl(b ^ c, 7);
  endfunction

  function automatic logic [511:0] ref_blk(logic [127:0] c, logic [255:0] k,
                                           logic [95:0] n, logic [31:0] ctr,
                                           int nr);
    bit [31:0] s [16];
    bit [31:0] x [16];
    logic [511:0] r;
    for (int i = 0; i < 4; i++) s[i] = c[32*i +: 32];
    for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
    s[12] = ctr;
    for (int i = 0; i < 3; i++) s[13+i] = n[32*i +: 32];
    x = s;
    for (int rd = 0; rd < nr; rd += 2) begin
      qround(x[0], x[4], x[8],  x[12]);
      qround(x[1], x[5], x[9],  x[13]);
      qround(x[2], x[6], x[10], x[14]);
      qround(x[3], x[7], x[11], x[15]);
      qround(x[0], x[5], x[10], x[15]);
      qround(x[1], x[6], x[11], x[12]);
      qround(x[2], x[7], x[8],  x[13]);
      qround(x[3], x[4], x[9],  x[14]);
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s[i];
    return r;
  endfunction

  // Driver: compute expected result, queue it, pulse start
  task automatic run_job(input bit b, input bit x, input int nr,
                         input logic [31:0] ctr, input logic [255:0] k,
                         input logic [95:0] n, input string tag);
    item_t it;
    int nb;
    nb = b ? BLOCKS : 1;
    it.exp = '0;
    for (int i = 0; i < nb; i++) begin
      it.exp[512*i +: 512] = ref_blk(SIGMA, k, n, ctr + 32'(i), nr)
                             ^ (x ? din[512*i +: 512] : 512'd0);
    end
    @(negedge clk);
    it.due = cyc + 1 + nb * (nr + 2);
    it.tag = tag;
    q.push_back(it);
    burst_en = b; xor_en = x; rounds = ROUND_W'(nr);
    ctr_in = ctr; key_in = k; nonce_in = n; const_in = SIGMA;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pop and compare on every done
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8", "unexpected done", dout, '0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(dout === it.exp, it.tag, "data", dout, it.exp);
        chk(cyc == it.due, "R3", "done cycle", BUF'(cyc), BUF'(it.due));
        chk(busy === 1'b0, "R3", "busy low at done", BUF'(busy), '0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] kv [32] = '{8'h76, 8'hb8, 8'he0, 8'had, 8'ha0, 8'hf1, 8'h3d, 8'h90,
                            8'h40, 8'h5d, 8'h6a, 8'he5, 8'h53, 8'h86, 8'hbd, 8'h28,
                            8'hbd, 8'hd2, 8'h19, 8'hb8, 8'ha0, 8'h8d, 8'hed, 8'h1a,
                            8'ha8, 8'h36, 8'hef, 8'hcc, 8'h8b, 8'h77, 8'h0d, 8'hc7};
    logic [255:0] k1;
    logic [95:0]  n1;
    logic [BUF-1:0] prev;
    bit vec_ok;

    rst = 1'b1; start = 0; burst_en = 0; xor_en = 0; rounds = '0;
    const_in = '0; key_in = '0; nonce_in = '0; ctr_in = '0;
    for (int i = 0; i < BUF / 8; i++) din[8*i +: 8] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(busy === 1'b0, "R10", "busy", BUF'(busy), '0);
    chk(done === 1'b0, "R10", "done", BUF'(done), '0);
    chk(err === 1'b0, "R10", "err", BUF'(err), '0);
    chk(dout === '0, "R10", "dout", dout, '0);

    // R2 known vector, single block, R9 upper bytes zero
    run_job(0, 0, 20, 32'd0, '0, '0, "R2/R9");
    wait_idle();
    vec_ok = 1;
    for (int i = 0; i < 32; i++) if (dout[8*i +: 8] !== kv[i]) vec_ok = 0;
    chk(vec_ok, "R2", "zero-key vector", dout, dout);
    chk(dout[BUF-1:512] === '0, "R9", "upper bytes zero", dout, '0);

    // R1 distinct key/nonce words, 8 rounds
    for (int i = 0; i < 32; i++) k1[8*i +: 8] = 8'(i + 1);
    n1 = 96'h000000_4a000000_09000000;
    run_job(0, 0, 8, 32'h00000001, k1, n1, "R1");
    wait_idle();

    // R4 burst of four, 12 rounds
    run_job(1, 0, 12, 32'h00001000, k1, n1, "R4");
    wait_idle();

    // R5 counter wrap inside a burst
    run_job(1, 0, 20, 32'hFFFFFFFE, k1, n1, "R5");
    wait_idle();

    // R6 XOR mode in burst, then single XOR (R9)
    run_job(1, 1, 20, 32'd7, k1, n1, "R6");
    wait_idle();
    run_job(0, 1, 8, 32'd3, k1, n1, "R6/R9");
    wait_idle();

    // R7 refused counts: zero and odd
    for (int t = 0; t < 2; t++) begin
      prev = dout;
      @(negedge clk);
      rounds = (t == 0) ? ROUND_W'(0) : ROUND_W'(7);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(err === 1'b1, "R7", "err pulse", BUF'(err), BUF'(1));
      chk(busy === 1'b0, "R7", "busy stays low", BUF'(busy), '0);
      repeat (30) @(negedge clk);
      chk(dout === prev, "R7", "dout kept", dout, prev);
    end

    // R8 start while busy is ignored
    run_job(0, 0, 20, 32'd5, k1, n1, "R8");
    repeat (3) @(negedge clk);
    key_in = ~k1; rounds = ROUND_W'(8); burst_en = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (60) @(negedge clk);
    chk(q.size() == 0, "R8", "no pending result", BUF'(q.size()), '0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule